// File: doc/BRIEF.md
# Two-Wire Slave Dual-Register Controller

This block is a slave on a two-wire serial bus. It holds two 8-bit registers. Register 0 is a general-purpose scratch byte. Register 1 sets a wiper position, and that position drives a one-hot selector over 256 taps. A fast system clock samples the bus clock and data lines through two-flop synchronisers. From these samples the block finds START, STOP and repeated START conditions. It answers by driving an open-drain enable on the data line.

A transfer opens with an address byte. The address is a fixed 4-bit code followed by the three select pins, and the last bit gives the direction. A write then carries a command byte, and the command picks which register or registers the following data byte or bytes update. A read has no command byte. It returns register 0, then register 1, then all-ones for as long as the master keeps acknowledging.

Top module: `tw_pot_ctrl`

## Requirements
- R1: The address byte is accepted only when its bits [7:4] are 4'b0101 and its bits [3:1] equal `dev_sel_i` (bit 3 = `dev_sel_i[2]`). Bit 0 selects a read when 1 and a write when 0. A byte that does not match gets no acknowledge, and the rest of the transfer is ignored.
- R2: `dev_sel_i` is compared at the moment the address byte completes, so a change to the pins takes effect on the next transfer.
- R3: Command 8'hA9 loads the next data byte into register 0. If the master sends a second data byte, that byte loads register 1.
- R4: Command 8'hAA loads the next data byte into register 1 only.
- R5: Command 8'hAF loads one data byte into both registers.
- R6: A read returns register 0 and then register 1, MSB first, and then 8'hFF for any further byte. After a not-acknowledge from the master, the block stops driving the data line.
- R7: Each accepted byte is acknowledged by holding the data line low for the whole high phase of the ninth clock.
- R8: A START or a STOP abandons any byte in progress. A partially shifted byte writes nothing, and a START begins a new address byte.
- R9: After reset, both registers are 8'h00, tap 0 is selected and the data line is released.
- R10: `tap_sel_o` has exactly one bit set, at the index equal to register 1.
- R11: A command byte other than A9h, AAh or AFh is not acknowledged, and the bytes that follow it are ignored until the next START.
- R12: The data-line enable changes only while the synchronised bus clock is low.
- R13: A data byte beyond those the command defines is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_sel_i | input | 3 | Pin-strapped device select bits |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| scratch_o | output | 8 | Register 0 |
| wiper_o | output | 8 | Register 1, the wiper position |
| tap_sel_o | output | 256 | One-hot tap select decoded from register 1 |

## Verification
A register load and the acknowledge of the byte that carries it come from the same bus-clock falling edge. Because of this, the register change and the rise of `sda_oe_o` fall in one system clock. The bench reads the new register value right after the ninth clock of each data byte. In the same transfer it samples the acknowledge early and late in that clock's high phase. A write is judged correct only when both the value and the acknowledge match. The bench also follows a data byte at once with a STOP, to show that the load has already committed before the bus is released.

// File: rtl/tw_pot_pkg.sv
package tw_pot_pkg;
  localparam logic [3:0] ID_CODE     = 4'b0101;
  localparam logic [7:0] CMD_WR_R0   = 8'hA9;
  localparam logic [7:0] CMD_WR_R1   = 8'hAA;
  localparam logic [7:0] CMD_WR_BOTH = 8'hAF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR_R0,
    ST_WR_R1,
    ST_WR_BOTH,
    ST_DONE,
    ST_SEND,
    ST_HALT
  } slv_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges with clock held high on both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_slave_fsm.sv
module tw_slave_fsm
  import tw_pot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] reg0_o,
  output logic [DATA_W-1:0] reg1_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] tx_q;
  logic [1:0]        tx_idx_q;
  logic              mack_q;
  logic              active;
  logic              addr_hit;
  logic [DATA_W-1:0] tx_next;

  assign active   = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign addr_hit = (shift_q[DATA_W-1:1] == {ID_CODE, dev_sel_i});

  always_comb begin
    unique case (tx_idx_q)
      2'd0:    tx_next = reg0_o;
      2'd1:    tx_next = reg1_o;
      default: tx_next = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shift_q  <= '0;
      tx_q     <= '1;
      tx_idx_q <= '0;
      mack_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      reg0_o   <= '0;
      reg1_o   <= '0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      tx_idx_q <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end else if (active) begin
      if (scl_rise_i) begin
        if (cnt_q < CNT_BYTE) shift_q <= {shift_q[DATA_W-2:0], sda_i};
        if (cnt_q == CNT_BYTE) mack_q <= ~sda_i;
        if (cnt_q != CNT_ACK) cnt_q <= cnt_q + 1'b1;
      end else if (scl_fall_i) begin
        if (cnt_q == CNT_BYTE) begin
          // byte complete: decide acknowledge and commit writes
          sda_oe_o <= 1'b0;
          unique case (state_q)
            ST_ADDR: begin
              if (addr_hit) begin
                sda_oe_o <= 1'b1;
                state_q  <= shift_q[0] ? ST_SEND : ST_CMD;
              end else begin
                state_q <= ST_HALT;
              end
            end
            ST_CMD: begin
              sda_oe_o <= 1'b1;
              unique case (shift_q)
                CMD_WR_R0:   state_q <= ST_WR_R0;
                CMD_WR_R1:   state_q <= ST_WR_R1;
                CMD_WR_BOTH: state_q <= ST_WR_BOTH;
                default: begin
                  sda_oe_o <= 1'b0;
                  state_q  <= ST_HALT;
                end
              endcase
            end
            ST_WR_R0: begin
              reg0_o   <= shift_q;
              sda_oe_o <= 1'b1;
              state_q  <= ST_WR_R1;
            end
            ST_WR_R1: begin
              reg1_o   <= shift_q;
              sda_oe_o <= 1'b1;
              state_q  <= ST_DONE;
            end
            ST_WR_BOTH: begin
              reg0_o   <= shift_q;
              reg1_o   <= shift_q;
              sda_oe_o <= 1'b1;
              state_q  <= ST_DONE;
            end
            ST_SEND: ;
            default: state_q <= ST_HALT;
          endcase
        end else if (cnt_q == CNT_ACK) begin
          cnt_q <= '0;
          if (state_q == ST_SEND) begin
            if (tx_idx_q == 2'd0 || mack_q) begin
              sda_oe_o <= ~tx_next[DATA_W-1];
              tx_q     <= {tx_next[DATA_W-2:0], 1'b1};
              if (tx_idx_q != 2'd2) tx_idx_q <= tx_idx_q + 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_HALT;
            end
          end else begin
            sda_oe_o <= 1'b0;
          end
        end else if (state_q == ST_SEND && cnt_q != '0) begin
          sda_oe_o <= ~tx_q[DATA_W-1];
          tx_q     <= {tx_q[DATA_W-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/tw_tap_decode.sv
module tw_tap_decode #(
  parameter int DATA_W = 8,
  localparam int TAPS  = 1 << DATA_W
) (
  input  logic [DATA_W-1:0] wiper_i,
  output logic [TAPS-1:0]   tap_o
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_o[i] = (wiper_i == DATA_W'(i));
  end
endmodule

// File: rtl/tw_pot_ctrl.sv
module tw_pot_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int TAPS       = 1 << DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  dev_sel_i,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] scratch_o,
  output logic [DATA_W-1:0] wiper_o,
  output logic [TAPS-1:0]   tap_sel_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  tw_slave_fsm #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .dev_sel_i  (dev_sel_i),
    .sda_oe_o   (sda_oe_o),
    .reg0_o     (scratch_o),
    .reg1_o     (wiper_o)
  );

  tw_tap_decode #(.DATA_W(DATA_W)) u_tap (
    .wiper_i (wiper_o),
    .tap_o   (tap_sel_o)
  );
endmodule

// File: rtl/tw_pot_ctrl_chk.sv
module tw_pot_ctrl_chk #(
  parameter int DATA_W = 8,
  localparam int TAPS  = 1 << DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              scl_fall_i,
  input logic              start_i,
  input logic              sda_oe_i,
  input logic [DATA_W-1:0] reg0_i,
  input logic [DATA_W-1:0] reg1_i,
  input logic [TAPS-1:0]   tap_i
);
  // R12
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !scl_s_i);

  // R7
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i) && $past(sda_oe_i)) |-> sda_oe_i);

  // R8
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  // R3
  reg0_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg0_i != $past(reg0_i)) |-> $past(scl_fall_i));

  // R4
  reg1_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg1_i != $past(reg1_i)) |-> $past(scl_fall_i));

  // R10
  tap_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(tap_i) == 1) && tap_i[reg1_i]);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      // R9
      reset_state_chk: assert (reg0_i == '0 && reg1_i == '0 && !sda_oe_i);
    end
  end
endmodule

bind tw_pot_ctrl tw_pot_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s_i    (scl_s),
  .scl_fall_i (scl_fall),
  .start_i    (start_det),
  .sda_oe_i   (sda_oe_o),
  .reg0_i     (scratch_o),
  .reg1_i     (wiper_o),
  .tap_i      (tap_sel_o)
);

// File: tb/tw_pot_ctrl_test.sv
`timescale 1ns/1ps
module tw_pot_ctrl_test;
  localparam int Q = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] sel = 3'd5;
  logic sda_oe;
  logic [7:0] scratch, wiper;
  logic [255:0] tap;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tw_pot_ctrl uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .dev_sel_i (sel),
    .sda_oe_o  (sda_oe),
    .scratch_o (scratch),
    .wiper_o   (wiper),
    .tap_sel_o (tap)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
    end
  endtask

  // returns 1 only if the line is low early and late in the ninth high phase
  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit a0, a1;
    send_bits(b, 8);
    sda_m = 1'b1; #Q; scl = 1'b1; #10; a0 = (sda_bus == 1'b0);
    #(2*Q - 20); a1 = (sda_bus == 1'b0); #10; scl = 1'b0; #Q;
    ack = a0 & a1;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; b[i] = sda_bus; #Q; scl = 1'b0; #Q;
    end
    sda_m = ~mack; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr(input logic [2:0] s, input bit rd);
    return {4'b0101, s, rd};
  endfunction

  // full write transfer of n bytes, acks[i] per byte
  task automatic wr_xfer(input logic [7:0] b0, b1, b2, b3, input int n, output logic [3:0] acks);
    logic [7:0] bs [4];
    bit a;
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    acks = '0;
    bus_start();
    for (int i = 0; i < n; i++) begin
      send_byte(bs[i], a);
      acks[i] = a;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk(scratch == 8'h00, "R9 scratch", scratch, 0);
    chk(wiper == 8'h00, "R9 wiper", wiper, 0);
    chk(tap == 256'd1, "R9 tap", tap[63:0], 1);
    chk(sda_oe == 1'b0, "R9 oe", sda_oe, 0);
  endtask

  task automatic t_write_r0();
    logic [3:0] a;
    wr_xfer(addr(3'd5, 0), 8'hA9, 8'h3C, 8'h00, 3, a);
    chk(a == 4'b0111, "R7 acks A9 single", a, 4'b0111);
    chk(scratch == 8'h3C, "R3 reg0", scratch, 8'h3C);
    chk(wiper == 8'h00, "R3 reg1 untouched", wiper, 0);
    wr_xfer(addr(3'd5, 0), 8'hA9, 8'h11, 8'h22, 4, a);
    chk(a == 4'b1111, "R3 acks optional", a, 4'b1111);
    chk(scratch == 8'h11 && wiper == 8'h22, "R3 both bytes", {scratch, wiper}, 16'h1122);
  endtask

  task automatic t_write_r1();
    logic [3:0] a;
    wr_xfer(addr(3'd5, 0), 8'hAA, 8'h80, 8'h00, 3, a);
    chk(a == 4'b0111, "R4 acks", a, 4'b0111);
    chk(wiper == 8'h80 && scratch == 8'h11, "R4 reg1 only", {scratch, wiper}, 16'h1180);
    chk(tap == (256'd1 << 8'h80), "R10 tap 80", tap[191:128], 64'd1);
    wr_xfer(addr(3'd5, 0), 8'hAA, 8'hFF, 8'h00, 3, a);
    chk(tap[255] && tap[254:0] == '0, "R10 tap 255", tap[255], 1);
  endtask

  task automatic t_write_both();
    logic [3:0] a;
    wr_xfer(addr(3'd5, 0), 8'hAF, 8'h5A, 8'h00, 3, a);
    chk(a == 4'b0111, "R5 acks", a, 4'b0111);
    chk(scratch == 8'h5A && wiper == 8'h5A, "R5 both", {scratch, wiper}, 16'h5A5A);
  endtask

  task automatic t_extra_byte();
    logic [3:0] a;
    wr_xfer(addr(3'd5, 0), 8'hAA, 8'h33, 8'h44, 4, a);
    chk(a == 4'b0111, "R13 extra nack", a, 4'b0111);
    chk(wiper == 8'h33 && scratch == 8'h5A, "R13 extra ignored", {scratch, wiper}, 16'h5A33);
  endtask

  task automatic t_bad_cmd();
    logic [3:0] a;
    wr_xfer(addr(3'd5, 0), 8'h55, 8'h77, 8'h00, 3, a);
    chk(a == 4'b0001, "R11 cmd nack", a, 4'b0001);
    chk(wiper == 8'h33 && scratch == 8'h5A, "R11 ignored", {scratch, wiper}, 16'h5A33);
  endtask

  task automatic t_addr();
    logic [3:0] a;
    wr_xfer(addr(3'd2, 0), 8'hAF, 8'h01, 8'h00, 3, a);
    chk(a == 4'b0000, "R1 wrong sel", a, 0);
    wr_xfer({4'b0110, 3'd5, 1'b0}, 8'hAF, 8'h01, 8'h00, 3, a);
    chk(a == 4'b0000, "R1 wrong code", a, 0);
    chk(wiper == 8'h33 && scratch == 8'h5A, "R1 regs kept", {scratch, wiper}, 16'h5A33);
    sel = 3'd2;
    wr_xfer(addr(3'd5, 0), 8'hAF, 8'h02, 8'h00, 3, a);
    chk(a == 4'b0000, "R2 old sel", a, 0);
    wr_xfer(addr(3'd2, 0), 8'hAF, 8'h03, 8'h00, 3, a);
    chk(a == 4'b0111 && wiper == 8'h03, "R2 new sel", {a, wiper}, 12'h703);
    sel = 3'd5;
  endtask

  task automatic t_read();
    logic [3:0] a;
    logic [7:0] r;
    bit ak;
    wr_xfer(addr(3'd5, 0), 8'hA9, 8'hC3, 8'h96, 4, a);
    bus_start();
    send_byte(addr(3'd5, 1), ak);
    chk(ak, "R1 read addr ack", ak, 1);
    recv_byte(1, r); chk(r == 8'hC3, "R6 reg0", r, 8'hC3);
    recv_byte(1, r); chk(r == 8'h96, "R6 reg1", r, 8'h96);
    recv_byte(1, r); chk(r == 8'hFF, "R6 beyond", r, 8'hFF);
    recv_byte(0, r); chk(r == 8'hFF, "R6 beyond2", r, 8'hFF);
    #Q; chk(sda_oe == 1'b0, "R6 released", sda_oe, 0);
    bus_stop();
    bus_start();
    send_byte(addr(3'd5, 1), ak);
    recv_byte(0, r); chk(r == 8'hC3, "R6 single", r, 8'hC3);
    sda_m = 1'b1; #Q; scl = 1'b1; #Q;
    chk(sda_oe == 1'b0, "R6 no drive after nack", sda_oe, 0);
    #Q; scl = 1'b0; #Q;
    bus_stop();
  endtask

  task automatic t_abort();
    bit ak;
    logic [3:0] a;
    bus_start();
    send_byte(addr(3'd5, 0), ak);
    send_byte(8'hAF, ak);
    send_bits(8'hF0, 4);
    bus_start();
    send_byte(addr(3'd5, 0), ak);
    chk(ak, "R8 restart addr", ak, 1);
    send_byte(8'hAA, ak);
    send_byte(8'h10, ak);
    bus_stop();
    chk(wiper == 8'h10 && scratch == 8'hC3, "R8 partial dropped", {scratch, wiper}, 16'hC310);
    bus_start();
    send_bits(addr(3'd5, 0), 5);
    bus_stop();
    wr_xfer(addr(3'd5, 0), 8'hA9, 8'h44, 8'h00, 3, a);
    chk(a == 4'b0111 && scratch == 8'h44, "R8 after stop", {a, scratch}, 12'h744);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #53 rst_n = 1'b1;
    #100;
    t_reset();
    t_write_r0();
    t_write_r1();
    t_write_both();
    t_extra_byte();
    t_bad_cmd();
    t_addr();
    t_read();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule